// File: doc/BRIEF.md
# Supervisor Double-Trap Escalation Unit

This unit keeps the supervisor-level "traps disabled" bit, the interrupt-enable bit that the disable bit gates, and the two environment-configuration enables for the feature. It keeps one copy of these bits for the ordinary supervisor and one for the virtual supervisor. Every trap that the core commits passes through the unit in the commit cycle. A supervisor-bound trap that arrives while the active disable bit is clear is delivered normally, and the unit sets the disable bit. A supervisor-bound trap that arrives while the active disable bit is already set is an unexpected trap. The unit sends it to machine level with a fixed double-trap cause, and it supplies the original cause as the value for the second trap-value register.

A machine-level enable and a hypervisor-level enable switch the feature on. When an enable is clear, the disable bits it governs read as zero and the unit does not check the traps they would guard. The virtualization input selects the copy of the bits that a trap check or a supervisor return uses. The escalation decision is combinational, and every register update takes effect on the clock edge that closes the commit cycle.

Top module: `sdt_escalator`

## Requirements
- R1: After reset, both disable-trap bits, both interrupt-enable bits and both feature enables read 0.
- R2: A status write with the disable-trap value 1 leaves the interrupt-enable bit of that copy at 0 after the edge, whatever enable value the write carries, provided the feature is enabled for that copy.
- R3: A status write sets the interrupt-enable bit to 1 only when the same write carries a disable-trap value of 0, or when the feature is disabled for that copy.
- R4: A committed trap with `trap_to_s`=1 whose active disable-trap bit is 0 and whose check is enabled has these effects:
  - in the same cycle, `out_to_m`=0, `out_dbl`=0, `out_cause` equals `trap_cause`, and `out_mtval2_we`=0;
  - from the next cycle, the active disable-trap bit reads 1.
- R5: A committed trap with `trap_to_s`=1 whose active disable-trap bit is 1 and whose check is enabled has these effects in the same cycle:
  - `out_to_m`=1 and `out_dbl`=1;
  - `out_cause` equals `DBL_CODE` (default 16);
  - `out_mtval2_we`=1 and `out_mtval2` equals `trap_cause`.
- R6: A trap with `trap_to_s`=0 goes to machine level unchanged and is never escalated: `out_to_m`=1, `out_dbl`=0, `out_cause` equals `trap_cause`, and `out_mtval2_we`=0. Escalation never targets supervisor level, so a double trap can never be delegated.
- R7: A supervisor return clears the active disable-trap bit from the next cycle.
- R8: While the machine enable is 0, both disable-trap bits and the hypervisor enable read 0. Supervisor-bound traps are then neither escalated nor recorded.
- R9: While the hypervisor enable is 0, the virtual disable-trap bit reads 0. Traps taken with `virt_on`=1 are then neither escalated nor recorded.
- R10: With `virt_on`=1, the trap check, the set on delivery and the clear on return all use the virtual copy, and the supervisor copy is left untouched. With `virt_on`=0, the roles of the two copies are reversed.
- R11: Events in one cycle apply in this order, each overriding the one before: status write, then return clear, then trap set. The escalation decision uses the register values from before the edge. An enable written 0 in a cycle clears the bits it governs on that same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_menv_we | input | 1 | Write the machine feature enable |
| cfg_menv_dte | input | 1 | Machine feature enable write value |
| cfg_henv_we | input | 1 | Write the hypervisor feature enable |
| cfg_henv_dte | input | 1 | Hypervisor feature enable write value |
| st_we | input | 2 | Status write strobes: bit 0 supervisor copy, bit 1 virtual copy |
| st_wdt | input | 1 | Disable-trap value of the status write |
| st_wie | input | 1 | Interrupt-enable value of the status write |
| virt_on | input | 1 | Virtualization mode active |
| sret_exec | input | 1 | Supervisor return retires this cycle |
| trap_valid | input | 1 | A trap commits this cycle |
| trap_to_s | input | 1 | The trap targets supervisor level (0: machine level) |
| trap_cause | input | CAUSE_W | Cause code of the trap |
| out_to_m | output | 1 | Trap is delivered to machine level |
| out_cause | output | CAUSE_W | Cause value to record for the delivered trap |
| out_dbl | output | 1 | Trap was escalated as a double trap |
| out_mtval2_we | output | 1 | Write the second trap-value register |
| out_mtval2 | output | CAUSE_W | Value for the second trap-value register |
| rd_s_dt | output | 1 | Supervisor disable-trap bit |
| rd_s_ie | output | 1 | Supervisor interrupt-enable bit |
| rd_vs_dt | output | 1 | Virtual supervisor disable-trap bit |
| rd_vs_ie | output | 1 | Virtual supervisor interrupt-enable bit |
| rd_menv_dte | output | 1 | Machine feature enable |
| rd_henv_dte | output | 1 | Hypervisor feature enable, as read |

## Verification
The assertions assume that `trap_to_s` and `trap_cause` matter only while `trap_valid` is high. They also assume that the core never asks the unit to escalate a trap it has already escalated. The directed stimulus holds one kind of event per cycle, except in one section that deliberately stacks a status write, a return and a trap in the same cycle to exercise the ordering rule. A final pseudo-random section draws all inputs freely. The reference model follows that same ordering, so colliding events stay within the stated behaviour.

// File: rtl/sdt_escalator_pkg.sv
package sdt_escalator_pkg;
  localparam int unsigned DBL_TRAP_CODE = 16;
  localparam int unsigned NUM_COPIES    = 2;
  localparam int unsigned IDX_S         = 0;
  localparam int unsigned IDX_VS        = 1;
endpackage

// File: rtl/sdt_env.sv
module sdt_env (
  input  logic clk,
  input  logic rst_n,
  input  logic menv_we,
  input  logic menv_wval,
  input  logic henv_we,
  input  logic henv_wval,
  output logic menv_q,
  output logic henv_q,
  output logic menv_d,
  output logic henv_d
);
  logic upd;

  always_comb begin
    menv_d = menv_we ? menv_wval : menv_q;
    henv_d = (henv_we ? henv_wval : henv_q) & menv_d;
    upd    = menv_we | henv_we | (henv_q & ~menv_d);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      menv_q <= 1'b0;
      henv_q <= 1'b0;
    end else if (upd) begin
      menv_q <= menv_d;
      henv_q <= henv_d;
    end
  end

  // R8: hypervisor enable cannot be on while the machine enable is off
  p_henv_gated_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !menv_q |-> !henv_q);
endmodule

// File: rtl/sdt_copy.sv
module sdt_copy (
  input  logic clk,
  input  logic rst_n,
  input  logic en_q,
  input  logic en_d,
  input  logic wr_en,
  input  logic wr_dt,
  input  logic wr_ie,
  input  logic clr,
  input  logic set,
  output logic dt_q,
  output logic ie_q
);
  logic dt_d, ie_d, upd, wdt_eff;

  always_comb begin
    wdt_eff = wr_dt & en_d;
    dt_d    = dt_q;
    ie_d    = ie_q;
    if (wr_en) begin
      dt_d = wdt_eff;
      ie_d = wr_ie & ~wdt_eff;
    end
    if (clr)   dt_d = 1'b0;
    if (set)   dt_d = 1'b1;
    if (!en_d) dt_d = 1'b0;
    upd = wr_en | clr | set | ~en_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dt_q <= 1'b0;
      ie_q <= 1'b0;
    end else if (upd) begin
      dt_q <= dt_d;
      ie_q <= ie_d;
    end
  end

  p_ie_forced_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_dt && en_d) |=> !ie_q);
  p_set_on_trap_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (set && en_d) |=> dt_q);
  p_ret_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && !set) |=> !dt_q);
  p_off_reads_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !en_q |-> !dt_q);
endmodule

// File: rtl/sdt_route.sv
module sdt_route #(
  parameter int unsigned CAUSE_W  = 6,
  parameter int unsigned DBL_CODE = 16,
  parameter int unsigned NCOPY    = 2
) (
  input  logic               trap_valid,
  input  logic               trap_to_s,
  input  logic [CAUSE_W-1:0] trap_cause,
  input  logic               virt_on,
  input  logic [NCOPY-1:0]   dt_cur,
  input  logic [NCOPY-1:0]   chk_en,
  output logic               to_m,
  output logic [CAUSE_W-1:0] cause_out,
  output logic               dbl,
  output logic               mtval2_we,
  output logic [CAUSE_W-1:0] mtval2,
  output logic [NCOPY-1:0]   set_vec
);
  import sdt_escalator_pkg::*;
  localparam logic [CAUSE_W-1:0] DBL_VAL = CAUSE_W'(DBL_CODE);

  logic hit_s, act_dt, act_chk;

  always_comb begin
    act_dt    = virt_on ? dt_cur[IDX_VS] : dt_cur[IDX_S];
    act_chk   = virt_on ? chk_en[IDX_VS] : chk_en[IDX_S];
    hit_s     = trap_valid & trap_to_s;
    dbl       = hit_s & act_chk & act_dt;
    to_m      = trap_valid & (~trap_to_s | dbl);
    cause_out = !trap_valid ? '0 : (dbl ? DBL_VAL : trap_cause);
    mtval2_we = dbl;
    mtval2    = dbl ? trap_cause : '0;
    set_vec         = '0;
    set_vec[IDX_S]  = hit_s & act_chk & ~act_dt & ~virt_on;
    set_vec[IDX_VS] = hit_s & act_chk & ~act_dt & virt_on;
  end

  // R10: at most one copy is marked per trap
  always_comb begin
    p_one_copy_r10: assert ($onehot0(set_vec));
  end
endmodule

// File: rtl/sdt_escalator.sv
module sdt_escalator
  import sdt_escalator_pkg::*;
#(
  parameter int unsigned CAUSE_W  = 6,
  parameter int unsigned DBL_CODE = DBL_TRAP_CODE
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cfg_menv_we,
  input  logic               cfg_menv_dte,
  input  logic               cfg_henv_we,
  input  logic               cfg_henv_dte,
  input  logic [1:0]         st_we,
  input  logic               st_wdt,
  input  logic               st_wie,
  input  logic               virt_on,
  input  logic               sret_exec,
  input  logic               trap_valid,
  input  logic               trap_to_s,
  input  logic [CAUSE_W-1:0] trap_cause,
  output logic               out_to_m,
  output logic [CAUSE_W-1:0] out_cause,
  output logic               out_dbl,
  output logic               out_mtval2_we,
  output logic [CAUSE_W-1:0] out_mtval2,
  output logic               rd_s_dt,
  output logic               rd_s_ie,
  output logic               rd_vs_dt,
  output logic               rd_vs_ie,
  output logic               rd_menv_dte,
  output logic               rd_henv_dte
);
  localparam int unsigned NCOPY = NUM_COPIES;

  logic menv_q, henv_q, menv_d, henv_d;
  logic [NCOPY-1:0] en_q_vec, en_d_vec, clr_vec, set_vec, dt_vec, ie_vec;

  sdt_env u_env (
    .clk(clk), .rst_n(rst_n),
    .menv_we(cfg_menv_we), .menv_wval(cfg_menv_dte),
    .henv_we(cfg_henv_we), .henv_wval(cfg_henv_dte),
    .menv_q(menv_q), .henv_q(henv_q), .menv_d(menv_d), .henv_d(henv_d)
  );

  always_comb begin
    en_q_vec         = '0;
    en_d_vec         = '0;
    clr_vec          = '0;
    en_q_vec[IDX_S]  = menv_q;
    en_q_vec[IDX_VS] = menv_q & henv_q;
    en_d_vec[IDX_S]  = menv_d;
    en_d_vec[IDX_VS] = henv_d;
    clr_vec[IDX_S]   = sret_exec & ~virt_on;
    clr_vec[IDX_VS]  = sret_exec & virt_on;
  end

  sdt_route #(.CAUSE_W(CAUSE_W), .DBL_CODE(DBL_CODE), .NCOPY(NCOPY)) u_route (
    .trap_valid(trap_valid), .trap_to_s(trap_to_s), .trap_cause(trap_cause),
    .virt_on(virt_on), .dt_cur(dt_vec), .chk_en(en_q_vec),
    .to_m(out_to_m), .cause_out(out_cause), .dbl(out_dbl),
    .mtval2_we(out_mtval2_we), .mtval2(out_mtval2), .set_vec(set_vec)
  );

  for (genvar g = 0; g < NCOPY; g++) begin : g_copy
    sdt_copy u_copy (
      .clk(clk), .rst_n(rst_n),
      .en_q(en_q_vec[g]), .en_d(en_d_vec[g]),
      .wr_en(st_we[g]), .wr_dt(st_wdt), .wr_ie(st_wie),
      .clr(clr_vec[g]), .set(set_vec[g]),
      .dt_q(dt_vec[g]), .ie_q(ie_vec[g])
    );
  end

  assign rd_s_dt     = dt_vec[IDX_S];
  assign rd_s_ie     = ie_vec[IDX_S];
  assign rd_vs_dt    = dt_vec[IDX_VS];
  assign rd_vs_ie    = ie_vec[IDX_VS];
  assign rd_menv_dte = menv_q;
  assign rd_henv_dte = henv_q;

  p_dbl_needs_dt_r5: assert property (@(posedge clk) disable iff (!rst_n)
    out_dbl |-> (trap_valid && trap_to_s && (virt_on ? rd_vs_dt : rd_s_dt)
                 && out_to_m && out_mtval2 == trap_cause
                 && out_cause == CAUSE_W'(DBL_CODE)));
  p_mtarget_pass_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (trap_valid && !trap_to_s) |-> (out_to_m && !out_dbl && !out_mtval2_we
                                    && out_cause == trap_cause));
  p_virt_keeps_s_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (virt_on && !st_we[IDX_S] && menv_d) |=> $stable(rd_s_dt));
endmodule

// File: tb/sdt_escalator_tb.sv
module sdt_escalator_tb;
  localparam int CW = 6;
  logic clk = 1'b0;
  logic rst_n;
  logic cfg_menv_we, cfg_menv_dte, cfg_henv_we, cfg_henv_dte;
  logic [1:0] st_we;
  logic st_wdt, st_wie, virt_on, sret_exec, trap_valid, trap_to_s;
  logic [CW-1:0] trap_cause;
  logic out_to_m, out_dbl, out_mtval2_we;
  logic [CW-1:0] out_cause, out_mtval2;
  logic rd_s_dt, rd_s_ie, rd_vs_dt, rd_vs_ie, rd_menv_dte, rd_henv_dte;

  int n_run = 0, n_fail = 0;
  bit done = 0;
  // reference state
  bit m_menv, m_henv, m_sdt, m_sie, m_vdt, m_vie;

  always #5 clk = ~clk;

  sdt_escalator #(.CAUSE_W(CW)) u_dut (.*);

  task automatic chk(input string tag, input string what, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic idle();
    cfg_menv_we = 0; cfg_menv_dte = 0; cfg_henv_we = 0; cfg_henv_dte = 0;
    st_we = 2'b00; st_wdt = 0; st_wie = 0; virt_on = 0; sret_exec = 0;
    trap_valid = 0; trap_to_s = 0; trap_cause = '0;
  endtask

  // called right after a falling edge with inputs driven
  task automatic tick(input string tag);
    bit chk_on, adt, dbl, en_s, en_v, dt, ie, wd;
    int ecause;
    #1;
    chk(tag, "rd_menv_dte", rd_menv_dte, m_menv);
    chk(tag, "rd_henv_dte", rd_henv_dte, m_henv);
    chk(tag, "rd_s_dt", rd_s_dt, m_sdt);
    chk(tag, "rd_s_ie", rd_s_ie, m_sie);
    chk(tag, "rd_vs_dt", rd_vs_dt, m_vdt);
    chk(tag, "rd_vs_ie", rd_vs_ie, m_vie);
    chk_on = virt_on ? (m_menv && m_henv) : m_menv;
    adt    = virt_on ? m_vdt : m_sdt;
    dbl    = trap_valid && trap_to_s && chk_on && adt;
    ecause = !trap_valid ? 0 : (dbl ? 16 : int'(trap_cause));
    chk(tag, "out_dbl", out_dbl, dbl);
    chk(tag, "out_to_m", out_to_m, trap_valid && (!trap_to_s || dbl));
    chk(tag, "out_cause", out_cause, ecause);
    chk(tag, "out_mtval2_we", out_mtval2_we, dbl);
    chk(tag, "out_mtval2", out_mtval2, dbl ? int'(trap_cause) : 0);
    // next state: write, then return, then trap, then enable gating
    en_s = cfg_menv_we ? cfg_menv_dte : m_menv;
    en_v = (cfg_henv_we ? cfg_henv_dte : m_henv) && en_s;
    dt = m_sdt; ie = m_sie;
    if (st_we[0]) begin wd = st_wdt && en_s; dt = wd; ie = st_wie && !wd; end
    if (sret_exec && !virt_on) dt = 0;
    if (trap_valid && trap_to_s && chk_on && !adt && !virt_on) dt = 1;
    if (!en_s) dt = 0;
    @(posedge clk);
    m_sdt = dt; m_sie = ie;
    dt = m_vdt; ie = m_vie;
    if (st_we[1]) begin wd = st_wdt && en_v; dt = wd; ie = st_wie && !wd; end
    if (sret_exec && virt_on) dt = 0;
    if (trap_valid && trap_to_s && chk_on && !adt && virt_on) dt = 1;
    if (!en_v) dt = 0;
    m_vdt = dt; m_vie = ie;
    m_menv = en_s; m_henv = en_v;
    @(negedge clk);
    idle();
  endtask

  task automatic wr_st(input int cp, input bit d, input bit e, input string tag);
    st_we[cp] = 1'b1; st_wdt = d; st_wie = e; tick(tag);
  endtask

  task automatic trap(input bit v, input bit s, input int c, input string tag);
    virt_on = v; trap_valid = 1; trap_to_s = s; trap_cause = CW'(c); tick(tag);
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    idle();
    rst_n = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1;
    tick("R1");
    // feature disabled: no checking, nothing recorded
    trap(0, 1, 8, "R8");
    trap(0, 1, 8, "R8");
    wr_st(0, 1, 1, "R3");          // disabled: ie free, dt reads 0
    cfg_henv_we = 1; cfg_henv_dte = 1; tick("R8");
    cfg_menv_we = 1; cfg_menv_dte = 1; tick("R8");
    wr_st(0, 1, 1, "R2");
    tick("R2");
    wr_st(0, 0, 1, "R3");
    wr_st(0, 1, 1, "R3");
    wr_st(0, 0, 0, "R3");
    trap(0, 1, 13, "R4");
    trap(0, 1, 5, "R5");
    trap(0, 0, 11, "R6");
    trap(0, 1, 63, "R5");
    sret_exec = 1; tick("R7");
    tick("R7");
    // virtual copy with hypervisor enable off
    wr_st(1, 1, 1, "R9");
    trap(1, 1, 20, "R9");
    trap(1, 1, 20, "R9");
    cfg_henv_we = 1; cfg_henv_dte = 1; tick("R10");
    trap(0, 1, 2, "R10");           // supervisor copy set
    trap(1, 1, 7, "R10");           // virtual copy set, supervisor unchanged
    trap(1, 1, 9, "R10");           // virtual double trap
    virt_on = 1; sret_exec = 1; tick("R10");
    trap(0, 1, 3, "R10");           // supervisor still set -> escalate
    virt_on = 0; sret_exec = 1; tick("R7");
    // same-cycle ordering
    trap(0, 1, 4, "R11");
    st_we = 2'b01; st_wdt = 0; st_wie = 1;
    trap_valid = 1; trap_to_s = 1; trap_cause = 6'd12; tick("R11");
    st_we = 2'b01; st_wdt = 0; st_wie = 0; sret_exec = 1;
    trap_valid = 1; trap_to_s = 1; trap_cause = 6'd14; tick("R11");
    st_we = 2'b01; st_wdt = 1; sret_exec = 1; tick("R11");
    cfg_menv_we = 1; cfg_menv_dte = 0; tick("R8");
    tick("R8");
    trap(0, 1, 6, "R8");
    cfg_menv_we = 1; cfg_menv_dte = 1; tick("R11");
    for (int i = 0; i < 400; i++) begin
      cfg_menv_we  = ($urandom % 16) == 0;
      cfg_menv_dte = ($urandom % 4) != 0;
      cfg_henv_we  = ($urandom % 8) == 0;
      cfg_henv_dte = $urandom % 2;
      st_we  = 2'(($urandom % 4 == 0) ? $urandom : 0);
      st_wdt = $urandom % 2; st_wie = $urandom % 2;
      virt_on = $urandom % 2;
      sret_exec = ($urandom % 5) == 0;
      trap_valid = ($urandom % 3) == 0;
      trap_to_s = trap_valid && (($urandom % 4) != 0);
      trap_cause = trap_valid ? CW'($urandom % 24) : '0;
      tick("R11");
    end
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule